// File: doc/BRIEF.md
# Address Range Attribute Register Unit

This block keeps eight programmable physical address windows and tells the memory path, within the same cycle, whether an address falls inside one of them and whether that window must bypass the cache. Each window has a base address, a power-of-two size code and a control byte. Software programs them through a small index/data byte port, which also exposes seven general configuration bytes. Those bytes hold the mapping-enable nibble, the global lookup enable, and the lock and write-protect controls for one guarded window.

A lookup compares the 32-bit address against every window in parallel. The lowest-numbered window that matches supplies the window number and its cache attribute. The last window uses a coarser size granule and the opposite polarity for its cache bit. The guarded window (number 3) can be frozen by a write-protect bit, or by a sticky lock bit that only reset clears.

Top module: `range_attr_unit`

## Requirements
- R1: After reset every configuration byte, descriptor byte and control byte reads 0, and every lookup returns hit=0 and uncached=0.
- R2: The configuration bytes are always readable and writable: bytes 0 to 3 at indices 0x20 to 0x23, and bytes 4 to 6 at indices 0x28 to 0x2A. Any other index that is not a window byte reads 0.
- R3: Window n's descriptor bytes sit at indices 0x30+3n, 0x31+3n and 0x32+3n, and its control byte sits at 0x50+n. These bytes can be read and written only while bits [7:4] of configuration byte 3 equal 4'b0001. Otherwise they read 0 and writes to them are dropped.
- R4: The descriptor bytes hold base bits [31:24], then base bits [23:16], then base bits [15:12] in bits [7:4] with the size code in bits [3:0]. For windows 0 to 6, a code c from 1 to 14 spans 4 KiB << (c-1), aligned as addr and base agree above that size.
- R5: For window 7, a code c from 1 to 14 spans 256 KiB << (c-1).
- R6: A window with size code 0 or code 0xF never matches.
- R7: When several windows match, the lowest-numbered one is reported on lk_idx.
- R8: Bit 0 of the control byte means cache-disable for windows 0 to 6 and cache-enable for window 7. lk_uncached follows it for the reported window and is 0 when there is no hit.
- R9: When bit 5 of configuration byte 5 is 0, lk_hit is 0 for every address.
- R10: Bit 0 of configuration byte 3 is a lock. Once it is set, writes cannot clear it, only reset can. While it is set, writes to window 3's descriptor bytes and control byte are dropped.
- R11: While bit 1 of configuration byte 6 is 1, writes to window 3's descriptor bytes and control byte are dropped.
- R12: Reads and lookups are combinational from the stored state. A write becomes visible only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the byte port |
| cfg_idx | input | 8 | Byte index for reads and writes |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for cfg_idx (combinational) |
| lk_addr | input | 32 | Physical address to look up |
| lk_hit | output | 1 | Some enabled window matches |
| lk_idx | output | 3 | Number of the matching window with the lowest number |
| lk_uncached | output | 1 | The reported window must not be cached |

## Verification
The assertions assume that cfg_idx, cfg_we and cfg_wdata hold steady around each rising edge, and that reset is released away from an edge. The bench meets this by changing every input on the falling edge and by releasing reset there. The property on dropped writes to window 3 also assumes that only a write can change a stored control byte. The random phase keeps the mapping-enable and lock byte out of its write mix, so the window bytes stay reachable. It keeps the global enable set most of the time and aims lookup addresses at or near a programmed base, so that hits, misses and overlaps all occur.

// File: rtl/range_attr_pkg.sv
package range_attr_pkg;
  // count of general configuration bytes
  localparam int CFG_BYTES = 7;
  // bytes per window descriptor
  localparam int DESC_BYTES = 3;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/range_attr_regs.sv
module range_attr_regs
  import range_attr_pkg::*;
#(
  parameter int NUM_RANGES = 8,
  parameter int IDX_W      = 8,
  parameter int GRPA_BASE  = 'h20,
  parameter int GRPB_BASE  = 'h28,
  parameter int DESC_BASE  = 'h30,
  parameter int CTL_BASE   = 'h50,
  parameter int PROT_RANGE = 3
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  cfg_we,
  input  logic [IDX_W-1:0]                      cfg_idx,
  input  logic [7:0]                            cfg_wdata,
  output logic [7:0]                            cfg_rdata,
  output logic [DESC_BYTES*NUM_RANGES-1:0][7:0] dsc_o,
  output logic [NUM_RANGES-1:0][7:0]            ctl_o,
  output logic                                  lock_o,
  output logic                                  map_en_o,
  output logic                                  glob_en_o
);
  localparam int NUM_DSC = DESC_BYTES * NUM_RANGES;
  localparam int GRPA_N  = 4;
  localparam int GRPB_N  = CFG_BYTES - GRPA_N;

  logic [CFG_BYTES-1:0][7:0] cr_q, cr_d;
  logic [NUM_DSC-1:0][7:0]   dsc_q, dsc_d;
  logic [NUM_RANGES-1:0][7:0] ctl_q, ctl_d;
  logic map_en, prot_blk;

  assign map_en   = (cr_q[3][7:4] == 4'b0001);
  assign prot_blk = cr_q[3][0] | cr_q[6][1];

  // next state
  always_comb begin
    cr_d  = cr_q;
    dsc_d = dsc_q;
    ctl_d = ctl_q;
    for (int i = 0; i < GRPA_N; i++)
      if (cfg_idx == IDX_W'(GRPA_BASE + i)) cr_d[i] = cfg_wdata;
    for (int i = 0; i < GRPB_N; i++)
      if (cfg_idx == IDX_W'(GRPB_BASE + i)) cr_d[GRPA_N+i] = cfg_wdata;
    // lock bit is sticky
    cr_d[3][0] = cr_d[3][0] | cr_q[3][0];
    for (int j = 0; j < NUM_DSC; j++)
      if (map_en && cfg_idx == IDX_W'(DESC_BASE + j) &&
          !(prot_blk && (j / DESC_BYTES) == PROT_RANGE))
        dsc_d[j] = cfg_wdata;
    for (int n = 0; n < NUM_RANGES; n++)
      if (map_en && cfg_idx == IDX_W'(CTL_BASE + n) &&
          !(prot_blk && n == PROT_RANGE))
        ctl_d[n] = cfg_wdata;
  end

  // registers, clock enable is the write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr_q  <= '0;
      dsc_q <= '0;
      ctl_q <= '0;
    end else if (cfg_we) begin
      cr_q  <= cr_d;
      dsc_q <= dsc_d;
      ctl_q <= ctl_d;
    end
  end

  // read mux
  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < GRPA_N; i++)
      if (cfg_idx == IDX_W'(GRPA_BASE + i)) cfg_rdata = cr_q[i];
    for (int i = 0; i < GRPB_N; i++)
      if (cfg_idx == IDX_W'(GRPB_BASE + i)) cfg_rdata = cr_q[GRPA_N+i];
    for (int j = 0; j < NUM_DSC; j++)
      if (map_en && cfg_idx == IDX_W'(DESC_BASE + j)) cfg_rdata = dsc_q[j];
    for (int n = 0; n < NUM_RANGES; n++)
      if (map_en && cfg_idx == IDX_W'(CTL_BASE + n)) cfg_rdata = ctl_q[n];
  end

  assign dsc_o     = dsc_q;
  assign ctl_o     = ctl_q;
  assign lock_o    = cr_q[3][0];
  assign map_en_o  = map_en;
  assign glob_en_o = cr_q[5][5];
endmodule

// File: rtl/range_attr_match.sv
module range_attr_match #(
  parameter int ADDR_W    = 32,
  parameter int GRAN_LOG2 = 12
) (
  input  logic [ADDR_W-13:0] base_hi,
  input  logic [3:0]         code,
  input  logic [ADDR_W-1:0]  addr,
  output logic               hit
);
  logic [5:0]        sh;
  logic [ADDR_W-1:0] msk;
  logic [ADDR_W-1:0] base;

  always_comb begin
    sh   = 6'(GRAN_LOG2 - 1) + {2'b00, code};
    msk  = {ADDR_W{1'b1}} << sh;
    base = {base_hi, 12'h000};
    hit  = (code != 4'h0) && (code != 4'hF) && ((addr & msk) == (base & msk));
  end
endmodule

// File: rtl/range_attr_pick.sv
module range_attr_pick #(
  parameter int NUM_RANGES = 8,
  parameter int SEL_W      = $clog2(NUM_RANGES)
) (
  input  logic [NUM_RANGES-1:0] hits,
  input  logic [NUM_RANGES-1:0] uc_bits,
  output logic                  hit,
  output logic [SEL_W-1:0]      sel,
  output logic                  uncached
);
  // scan downward so the lowest index is the last assignment
  always_comb begin
    hit      = 1'b0;
    sel      = '0;
    uncached = 1'b0;
    for (int n = NUM_RANGES - 1; n >= 0; n--)
      if (hits[n]) begin
        hit      = 1'b1;
        sel      = SEL_W'(n);
        uncached = uc_bits[n];
      end
  end
endmodule

// File: rtl/range_attr_unit.sv
module range_attr_unit
  import range_attr_pkg::*;
#(
  parameter int NUM_RANGES     = 8,
  parameter int IDX_W          = 8,
  parameter int ADDR_W         = 32,
  parameter int GRAN_LOG2      = 12,
  parameter int LAST_GRAN_LOG2 = 18,
  parameter int GRPA_BASE      = 'h20,
  parameter int GRPB_BASE      = 'h28,
  parameter int DESC_BASE      = 'h30,
  parameter int CTL_BASE       = 'h50,
  parameter int PROT_RANGE     = 3,
  localparam int SEL_W         = $clog2(NUM_RANGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [SEL_W-1:0]  lk_idx,
  output logic              lk_uncached
);
  logic [DESC_BYTES*NUM_RANGES-1:0][7:0] dsc;
  logic [NUM_RANGES-1:0][7:0]            ctl;
  logic lock_q, map_en, glob_en;
  logic [NUM_RANGES-1:0] raw_hit, en_hit, uc_bit;
  logic [7:0] prot_ctl;

  range_attr_regs #(
    .NUM_RANGES(NUM_RANGES), .IDX_W(IDX_W), .GRPA_BASE(GRPA_BASE),
    .GRPB_BASE(GRPB_BASE), .DESC_BASE(DESC_BASE), .CTL_BASE(CTL_BASE),
    .PROT_RANGE(PROT_RANGE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dsc_o(dsc), .ctl_o(ctl),
    .lock_o(lock_q), .map_en_o(map_en), .glob_en_o(glob_en)
  );

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_rng
    localparam int GL = (g == NUM_RANGES - 1) ? LAST_GRAN_LOG2 : GRAN_LOG2;
    range_attr_match #(.ADDR_W(ADDR_W), .GRAN_LOG2(GL)) u_match (
      .base_hi({dsc[3*g], dsc[3*g+1], dsc[3*g+2][7:4]}),
      .code(dsc[3*g+2][3:0]),
      .addr(lk_addr),
      .hit(raw_hit[g])
    );
    if (g == NUM_RANGES - 1) begin : g_last
      assign uc_bit[g] = ~ctl[g][0];
    end else begin : g_norm
      assign uc_bit[g] = ctl[g][0];
    end
  end

  assign en_hit   = raw_hit & {NUM_RANGES{glob_en}};
  assign prot_ctl = ctl[PROT_RANGE];

  range_attr_pick #(.NUM_RANGES(NUM_RANGES)) u_pick (
    .hits(en_hit), .uc_bits(uc_bit), .hit(lk_hit), .sel(lk_idx),
    .uncached(lk_uncached)
  );
endmodule

// File: rtl/range_attr_chk.sv
module range_attr_chk #(
  parameter int NUM_RANGES = 8,
  parameter int IDX_W      = 8,
  parameter int DESC_BASE  = 'h30,
  parameter int CTL_BASE   = 'h50,
  parameter int PROT_RANGE = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [IDX_W-1:0] cfg_idx,
  input logic [7:0]       cfg_rdata,
  input logic             lk_hit,
  input logic             lk_uncached,
  input logic             lock_q,
  input logic             map_en,
  input logic             glob_en,
  input logic [7:0]       prot_ctl
);
  logic in_win;
  assign in_win = (cfg_idx >= IDX_W'(DESC_BASE)) &&
                  (cfg_idx < IDX_W'(DESC_BASE + 3 * NUM_RANGES));

  // R3
  win_closed_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!map_en && in_win) |-> (cfg_rdata == 8'h00));

  // R10
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  // R10
  locked_ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && cfg_we && cfg_idx == IDX_W'(CTL_BASE + PROT_RANGE)) |=> $stable(prot_ctl));

  // R8
  miss_cacheable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> !lk_uncached);

  // R9
  global_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |-> !lk_hit);
endmodule

bind range_attr_unit range_attr_chk #(
  .NUM_RANGES(NUM_RANGES), .IDX_W(IDX_W), .DESC_BASE(DESC_BASE),
  .CTL_BASE(CTL_BASE), .PROT_RANGE(PROT_RANGE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
  .cfg_rdata(cfg_rdata), .lk_hit(lk_hit), .lk_uncached(lk_uncached),
  .lock_q(lock_q), .map_en(map_en), .glob_en(glob_en), .prot_ctl(prot_ctl)
);

// File: tb/range_attr_unit_bench.sv
module range_attr_unit_bench;
  localparam int GA = 'h20, GB = 'h28, DB = 'h30, CB = 'h50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_idx = '0, cfg_wdata = '0, cfg_rdata;
  logic [31:0] lk_addr = '0;
  logic lk_hit, lk_uncached;
  logic [2:0] lk_idx;

  int checks = 0, errors = 0;
  logic [7:0] m_cr[7];
  logic [7:0] m_dsc[24];
  logic [7:0] m_ctl[8];

  always #5 clk = ~clk;

  range_attr_unit u_range_attr_unit (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_uncached(lk_uncached)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model_clear();
    for (int i = 0; i < 7; i++) m_cr[i] = '0;
    for (int i = 0; i < 24; i++) m_dsc[i] = '0;
    for (int i = 0; i < 8; i++) m_ctl[i] = '0;
  endfunction

  function automatic void model_wr(int idx, logic [7:0] d);
    logic mp, blk;
    mp  = (m_cr[3][7:4] == 4'b0001);
    blk = m_cr[3][0] | m_cr[6][1];
    for (int i = 0; i < 4; i++)
      if (idx == GA + i) m_cr[i] = (i == 3) ? (d | {7'b0, m_cr[3][0]}) : d;
    for (int i = 0; i < 3; i++) if (idx == GB + i) m_cr[4+i] = d;
    if (mp) begin
      for (int j = 0; j < 24; j++)
        if (idx == DB + j && !(blk && j / 3 == 3)) m_dsc[j] = d;
      for (int n = 0; n < 8; n++)
        if (idx == CB + n && !(blk && n == 3)) m_ctl[n] = d;
    end
  endfunction

  function automatic logic [7:0] model_rd(int idx);
    logic mp;
    mp = (m_cr[3][7:4] == 4'b0001);
    for (int i = 0; i < 4; i++) if (idx == GA + i) return m_cr[i];
    for (int i = 0; i < 3; i++) if (idx == GB + i) return m_cr[4+i];
    for (int j = 0; j < 24; j++) if (idx == DB + j) return mp ? m_dsc[j] : 8'h00;
    for (int n = 0; n < 8; n++) if (idx == CB + n) return mp ? m_ctl[n] : 8'h00;
    return 8'h00;
  endfunction

  function automatic int win_shift(int n);
    int c;
    c = int'(m_dsc[3*n+2][3:0]);
    if (c == 0 || c == 15) c = 1;
    return ((n == 7) ? 17 : 11) + c;
  endfunction

  function automatic logic [31:0] win_base(int n);
    return {m_dsc[3*n], m_dsc[3*n+1], m_dsc[3*n+2][7:4], 12'h000};
  endfunction

  // returns {hit, idx[2:0], uncached}
  function automatic logic [4:0] model_lk(logic [31:0] a);
    int c, k;
    if (!m_cr[5][5]) return 5'b0;
    for (int n = 0; n < 8; n++) begin
      c = int'(m_dsc[3*n+2][3:0]);
      if (c != 0 && c != 15) begin
        k = ((n == 7) ? 17 : 11) + c;
        if ((a >> k) == (win_base(n) >> k))
          return {1'b1, 3'(n), (n == 7) ? ~m_ctl[n][0] : m_ctl[n][0]};
      end
    end
    return 5'b0;
  endfunction

  task automatic wr(int idx, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 8'(idx); cfg_wdata = d;
    model_wr(idx, d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(int idx, string tag);
    @(negedge clk);
    cfg_idx = 8'(idx);
    #1;
    chk(tag, 32'(cfg_rdata), 32'(model_rd(idx)));
  endtask

  task automatic lk_chk(logic [31:0] a, string tag);
    logic [4:0] e;
    @(negedge clk);
    lk_addr = a;
    #1;
    e = model_lk(a);
    chk({tag, " hit"}, 32'(lk_hit), 32'(e[4]));
    if (e[4]) chk({tag, " idx"}, 32'(lk_idx), 32'(e[3:1]));
    chk({tag, " uncached"}, 32'(lk_uncached), 32'(e[0]));
  endtask

  task automatic set_win(int n, logic [31:0] base, logic [3:0] code, logic [7:0] c);
    wr(DB + 3*n, base[31:24]);
    wr(DB + 3*n + 1, base[23:16]);
    wr(DB + 3*n + 2, {base[15:12], code});
    wr(CB + n, c);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_clear();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #1500000;
    checks++; errors++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] a;
    int r, k, sel;
    logic [32:0] span;
    void'($urandom(32'd7321));
    model_clear();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int i = 0; i < 4; i++) rd_chk(GA + i, "R1 cfg grpA");
    for (int i = 0; i < 3; i++) rd_chk(GB + i, "R1 cfg grpB");
    lk_chk(32'h0000_0000, "R1 lookup");

    // R2: configuration bytes, unmapped index
    wr(GA, 8'h5A); rd_chk(GA, "R2 cfg0");
    wr(GB, 8'hA5); rd_chk(GB, "R2 cfg4");
    rd_chk(8'h24, "R2 gap index");

    // R12: write not visible before the edge
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 8'(GA + 1); cfg_wdata = 8'h3C;
    #1;
    chk("R12 before edge", 32'(cfg_rdata), 32'h00);
    model_wr(GA + 1, 8'h3C);
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    chk("R12 after edge", 32'(cfg_rdata), 32'h3C);

    // R3: mapping closed
    wr(DB, 8'hFF);
    wr(GA + 3, 8'h10);
    rd_chk(DB, "R3 write dropped while closed");
    wr(DB, 8'h77);
    wr(GA + 3, 8'h20);
    rd_chk(DB, "R3 read zero while closed");
    wr(GA + 3, 8'h10);
    rd_chk(DB, "R3 read open");

    // R4: small granule window 0
    wr(GB + 1, 8'h20);
    set_win(0, 32'h0010_0000, 4'h1, 8'h01);
    lk_chk(32'h0010_0FFF, "R4 4K top");
    lk_chk(32'h0010_1000, "R4 4K past");
    set_win(0, 32'h0010_0000, 4'h3, 8'h00);
    lk_chk(32'h0010_3FFF, "R4 16K top");
    lk_chk(32'h0010_4000, "R4 16K past");

    // R5 / R8: last window, inverted cache bit
    set_win(7, 32'h0400_0000, 4'h1, 8'h01);
    lk_chk(32'h0403_FFFF, "R5 256K top");
    lk_chk(32'h0404_0000, "R5 256K past");
    lk_chk(32'h0400_1000, "R8 last cache-enable");
    wr(CB + 7, 8'h00);
    lk_chk(32'h0400_1000, "R8 last cache-disable");

    // R6: code 0xF and code 0
    set_win(1, 32'h0000_0000, 4'hF, 8'h01);
    lk_chk(32'h0000_0010, "R6 code F");
    set_win(1, 32'h0000_0000, 4'h0, 8'h01);
    lk_chk(32'h0000_0010, "R6 code 0");

    // R7: overlap priority
    set_win(4, 32'h2000_0000, 4'h8, 8'h00);
    set_win(2, 32'h2000_0000, 4'h2, 8'h01);
    lk_chk(32'h2000_0100, "R7 overlap");
    lk_chk(32'h2000_4000, "R7 only upper");

    // R9: global enable off
    wr(GB + 1, 8'h00);
    lk_chk(32'h2000_0100, "R9 off");
    wr(GB + 1, 8'h20);

    // R11: write protect
    set_win(3, 32'h3000_0000, 4'h1, 8'h00);
    wr(GB + 2, 8'h02);
    wr(DB + 9, 8'hEE);
    rd_chk(DB + 9, "R11 protected descriptor");
    wr(CB + 3, 8'h01);
    rd_chk(CB + 3, "R11 protected control");
    wr(GB + 2, 8'h00);
    wr(CB + 3, 8'h01);
    rd_chk(CB + 3, "R11 unprotected control");

    // R10: lock
    wr(GA + 3, 8'h11);
    wr(GA + 3, 8'h10);
    rd_chk(GA + 3, "R10 lock sticky");
    wr(CB + 3, 8'h00);
    rd_chk(CB + 3, "R10 locked control");
    wr(DB + 10, 8'h44);
    rd_chk(DB + 10, "R10 locked descriptor");
    wr(CB + 2, 8'h00);
    rd_chk(CB + 2, "R10 other window writable");
    do_reset();
    rd_chk(GA + 3, "R10 cleared by reset");

    // random phase: R4 R5 R6 R7 R8 R9
    wr(GA + 3, 8'h10);
    wr(GB + 1, 8'h20);
    for (int it = 0; it < 600; it++) begin
      sel = int'($urandom % 10);
      if (sel < 5) wr(DB + int'($urandom % 24), 8'($urandom));
      else if (sel < 8) wr(CB + int'($urandom % 8), 8'($urandom));
      else if (sel == 8) wr(GB + 1, ($urandom % 4 == 0) ? 8'h00 : 8'h20);
      else wr(GB + 2, 8'($urandom) & 8'hFD);
      r = int'($urandom % 8);
      k = win_shift(r);
      span = (33'h1 << (k + 1)) - 33'h1;
      a = win_base(r) ^ ($urandom & span[31:0]);
      lk_chk(a, "R7 random lookup");
      if (it % 8 == 0) rd_chk(DB + int'($urandom % 24), "R3 random read");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule